// File: doc/BRIEF.md
# Timed Transmit Entry Scheduler

This block holds a small table of transmit-schedule entries for a serial avionics word transmitter. Every entry has a command word and a data word. The command word selects a timing source, a delay, and master or slave and recycle behaviour. The data word is the value to be sent. Host software fills the table through a simple write port and reads status back through a combinational read port.

Each enabled master counts pulses of its chosen tick source: the base tick or one of two prescaled ticks. When the count reaches the programmed delay, the master is marked for execution. Its slaves are marked in the same cycle. A slave belongs to the nearest master above it in the table and must carry the same source code as that master. Marked entries are handed to a downstream queue over a valid/ready handshake, lowest table index first. Each entry keeps sticky status flags: one that records a first completed output and one that records an overrun.

Top module: `txsched`

## Requirements
- R1: The source field (command bits 21:20) picks the tick input an entry counts. 00 means the entry is off and never fires, 01 selects `base_tick`, 10 selects `pre0_tick` and 11 selects `pre1_tick`. Pulses on the other tick inputs are not counted.
- R2: A master (bit 17 = 1) with delay D (bits 15:0) becomes marked on the D-th pulse of its selected tick after its command word is written. A delay of 0 behaves like a delay of 1.
- R3: A master with the recycle flag (bit 16) clear fires once and then stays idle until its command word is written again. A master with the flag set fires again every D selected ticks.
- R4: When a master fires, the slaves that follow it in the same cycle are also marked. These are the entries with bit 17 = 0 that sit below the master, up to the next master, and whose source field equals the master's. A slave whose source differs, or a slave with no master above it, is never marked. A slave's own delay and recycle bits are ignored.
- R5: `tx_valid` is high while any entry is marked. `tx_index` and `tx_data` then give the lowest marked index and that entry's data word. A cycle with `tx_valid` and `tx_ready` both high accepts the word and clears that entry's mark. While `tx_ready` is low and the host does not write, `tx_valid` stays high.
- R6: Reading a command word returns bit 24 = completed-once, bit 23 = marked, bit 22 = overrun, and the stored source, master, recycle and delay fields in the positions of R1 to R3. Bits 31:25, 19 and 18 always read 0, even when they were written as 1.
- R7: The completed-once flag is set when one of the entry's words is accepted. It stays set until the command word is written again or the block is reset.
- R8: The overrun flag is set on a master when its delay expires while the master, or one of its released slaves, is still marked. It stays set until the command word is written again or the block is reset.
- R9: The host address selects the data word when bit 0 is 1 and the command word when bit 0 is 0. The upper bits give the entry index. Writing a command word clears the entry's mark, status flags and counter, and status bits in the written value are ignored. Writing a data word leaves the status unchanged.
- R10: After reset every field reads 0 and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base timing pulse, one cycle wide |
| pre0_tick | input | 1 | First prescaled timing pulse |
| pre1_tick | input | 1 | Second prescaled timing pulse |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | IDX_W+1 | Write address: entry index in the upper bits, word select in bit 0 |
| host_wdata | input | 32 | Write data |
| host_raddr | input | IDX_W+1 | Read address, same layout as the write address |
| host_rdata | output | 32 | Read data for the entry and word selected by the read address |
| tx_valid | output | 1 | A marked entry is offered downstream |
| tx_ready | input | 1 | Downstream accepts the offered word |
| tx_data | output | 32 | Data word of the offered entry |
| tx_index | output | IDX_W | Table index of the offered entry |

## Verification
A table of single-master cases varies the source code, the tick line pulsed, the pulse count and the delay. It tells counting on the correct source apart from counting on any pulse, and it separates firing one tick early or late from firing on time, including the zero-delay case. Directed sequences then build a table with two groups, a slave whose source does not match, and an orphan slave. These show which entries are released together and the order in which they leave on the handshake. Repeated expiry with and without acceptance separates single-shot from recycling masters and separates clean repeats from overruns. The sticky flags are checked to survive acceptance and data writes and to clear on a command rewrite.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
    localparam int WORD_W  = 32;
    localparam int DELAY_W = 16;

    localparam int POS_DONE    = 24;
    localparam int POS_MARK    = 23;
    localparam int POS_OVR     = 22;
    localparam int POS_SRC     = 20;
    localparam int POS_MASTER  = 17;
    localparam int POS_RECYCLE = 16;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_BASE = 2'b01,
        SRC_PRE0 = 2'b10,
        SRC_PRE1 = 2'b11
    } src_e;

    typedef struct packed {
        src_e               src;
        logic               master;
        logic               recycle;
        logic [DELAY_W-1:0] delay;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.src     = src_e'(w[POS_SRC +: 2]);
        c.master  = w[POS_MASTER];
        c.recycle = w[POS_RECYCLE];
        c.delay   = w[DELAY_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] encode_status(input cmd_t c, input logic done,
                                                         input logic mark, input logic ovr);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[POS_DONE]      = done;
        w[POS_MARK]      = mark;
        w[POS_OVR]       = ovr;
        w[POS_SRC +: 2]  = c.src;
        w[POS_MASTER]    = c.master;
        w[POS_RECYCLE]   = c.recycle;
        w[DELAY_W-1:0]   = c.delay;
        return w;
    endfunction
endpackage

// File: rtl/txsched_slot.sv
module txsched_slot
    import txsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        ticks,
    input  logic              wr_cmd,
    input  logic              wr_data,
    input  logic [WORD_W-1:0] wdata,
    input  logic              release_i,
    input  logic              busy_i,
    input  logic              accept_i,
    output cmd_t              cmd_o,
    output logic              expire_o,
    output logic              marked_o,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] status_o
);
    cmd_t               cmd_q;
    logic [DELAY_W-1:0] cnt_q;
    logic               armed_q;
    logic               mark_q;
    logic               done_q;
    logic               ovr_q;
    logic [WORD_W-1:0]  data_q;
    logic               counting;
    logic               expire;

    always_comb begin
        counting = armed_q && cmd_q.master && (cmd_q.src != SRC_OFF) && ticks[cmd_q.src];
        expire   = counting && (({1'b0, cnt_q} + 1'b1) >= {1'b0, cmd_q.delay});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            mark_q  <= 1'b0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (wr_cmd) begin
            cmd_q   <= decode_cmd(wdata);
            cnt_q   <= '0;
            armed_q <= 1'b1;
            mark_q  <= 1'b0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (expire) begin
                cnt_q <= '0;
                if (!cmd_q.recycle) armed_q <= 1'b0;
                if (busy_i) ovr_q <= 1'b1;
            end else if (counting) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (release_i)     mark_q <= 1'b1;
            else if (accept_i) mark_q <= 1'b0;
            if (accept_i) done_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (wr_data) data_q <= wdata;
    end

    assign cmd_o    = cmd_q;
    assign expire_o = expire;
    assign marked_o = mark_q;
    assign data_o   = data_q;
    assign status_o = encode_status(cmd_q, done_q, mark_q, ovr_q);

    // R5 / R9: a mark only goes away through acceptance or a command rewrite
    a_r9_mark_clear_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(mark_q) |-> $past(accept_i || wr_cmd));
    // R7: completed-once is only ever set by an acceptance
    a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(accept_i));
    // R8: overrun is only ever set by an expiry
    a_r8_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(expire));
    // R3: a single-shot master cannot expire twice in a row without a rewrite
    a_r3_single_shot: assert property (@(posedge clk) disable iff (rst)
        (expire && !cmd_q.recycle && !wr_cmd) |=> !expire);
endmodule

// File: rtl/txsched_group.sv
module txsched_group #(
    parameter int N = 8
) (
    input  logic [N-1:0]      master,
    input  logic [N-1:0][1:0] src,
    input  logic [N-1:0]      expire,
    input  logic [N-1:0]      marked,
    output logic [N-1:0]      release_o,
    output logic [N-1:0]      busy_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]            tied;
    logic [N-1:0][IDX_W-1:0] owner;

    always_comb begin
        logic           have;
        logic [IDX_W-1:0] own;
        have      = 1'b0;
        own       = '0;
        tied      = '0;
        owner     = '0;
        release_o = '0;
        for (int i = 0; i < N; i++) begin
            if (master[i]) begin
                have         = 1'b1;
                own          = IDX_W'(i);
                release_o[i] = expire[i];
            end else begin
                tied[i]      = have && (src[i] == src[own]);
                owner[i]     = own;
                release_o[i] = tied[i] && expire[own];
            end
        end
    end

    always_comb begin
        busy_o = marked;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (tied[i] && (owner[i] == IDX_W'(j)) && marked[i]) busy_o[j] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/txsched_pick.sv
module txsched_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]                               marked,
    output logic                                       valid,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0]       idx
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    always_comb begin
        valid = |marked;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (marked[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txsched.sv
module txsched
    import txsched_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              pre0_tick,
    input  logic              pre1_tick,
    input  logic              host_wr,
    input  logic [IDX_W:0]    host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic [IDX_W:0]    host_raddr,
    output logic [31:0]       host_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic [IDX_W-1:0]  tx_index
);
    logic [3:0]         tick_v;
    cmd_t               cmd_a    [N];
    logic [WORD_W-1:0]  data_a   [N];
    logic [WORD_W-1:0]  status_a [N];
    logic [N-1:0]       master_v, expire_v, marked_v, release_v, busy_v, accept_v;
    logic [N-1:0][1:0]  src_v;
    logic [IDX_W-1:0]   widx, ridx;

    assign tick_v = {pre1_tick, pre0_tick, base_tick, 1'b0};
    assign widx   = host_waddr[IDX_W:1];
    assign ridx   = host_raddr[IDX_W:1];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic is_w;
        assign is_w        = host_wr && (widx == IDX_W'(g));
        assign accept_v[g] = tx_valid && tx_ready && (tx_index == IDX_W'(g));
        assign master_v[g] = cmd_a[g].master;
        assign src_v[g]    = cmd_a[g].src;

        txsched_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .ticks     (tick_v),
            .wr_cmd    (is_w && !host_waddr[0]),
            .wr_data   (is_w &&  host_waddr[0]),
            .wdata     (host_wdata),
            .release_i (release_v[g]),
            .busy_i    (busy_v[g]),
            .accept_i  (accept_v[g]),
            .cmd_o     (cmd_a[g]),
            .expire_o  (expire_v[g]),
            .marked_o  (marked_v[g]),
            .data_o    (data_a[g]),
            .status_o  (status_a[g])
        );
    end

    txsched_group #(.N(N)) u_group (
        .master    (master_v),
        .src       (src_v),
        .expire    (expire_v),
        .marked    (marked_v),
        .release_o (release_v),
        .busy_o    (busy_v)
    );

    txsched_pick #(.N(N)) u_pick (
        .marked (marked_v),
        .valid  (tx_valid),
        .idx    (tx_index)
    );

    always_comb begin
        host_rdata = '0;
        if (int'(ridx) < N) host_rdata = host_raddr[0] ? data_a[ridx] : status_a[ridx];
    end

    assign tx_data = data_a[tx_index];

    // R5: an offered word is held until accepted unless the host intervenes
    a_r5_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !host_wr) |=> tx_valid);
    // R5: an accepted entry that is not re-released leaves the output
    a_r5_accept_clears: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !host_wr && !release_v[tx_index]) |=> !marked_v[$past(tx_index)]);
endmodule

// File: tb/txsched_test.sv
`timescale 1ns/100ps
module txsched_test;
    localparam int N     = 8;
    localparam int IDX_W = 3;
    localparam int NV    = 8;
    // {src[31:30], tick[29:28], pulses[27:20], expect_mark[19], 3'b0, delay[15:0]}
    localparam logic [31:0] VEC [NV] = '{
        {2'd1, 2'd1, 8'd2, 1'b0, 3'd0, 16'd3},
        {2'd1, 2'd1, 8'd3, 1'b1, 3'd0, 16'd3},
        {2'd2, 2'd1, 8'd5, 1'b0, 3'd0, 16'd2},
        {2'd2, 2'd2, 8'd2, 1'b1, 3'd0, 16'd2},
        {2'd3, 2'd3, 8'd4, 1'b1, 3'd0, 16'd4},
        {2'd3, 2'd2, 8'd4, 1'b0, 3'd0, 16'd4},
        {2'd0, 2'd1, 8'd3, 1'b0, 3'd0, 16'd1},
        {2'd1, 2'd1, 8'd1, 1'b1, 3'd0, 16'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic base_tick = 1'b0, pre0_tick = 1'b0, pre1_tick = 1'b0;
    logic host_wr = 1'b0;
    logic [IDX_W:0] host_waddr = '0, host_raddr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic tx_valid, tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic [IDX_W-1:0] tx_index;

    int checks = 0, fails = 0, cycles = 0;

    always #2 clk = ~clk;

    txsched #(.N(N)) uut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .pre0_tick(pre0_tick),
        .pre1_tick(pre1_tick), .host_wr(host_wr), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_index(tx_index)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input bit sel, input logic [31:0] d);
        host_wr = 1'b1; host_waddr = {IDX_W'(idx), sel}; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int idx, input bit sel, output logic [31:0] d);
        host_raddr = {IDX_W'(idx), sel};
        #1 d = host_rdata;
    endtask

    task automatic pulse(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            base_tick = (which == 1); pre0_tick = (which == 2); pre1_tick = (which == 3);
            @(negedge clk);
            base_tick = 1'b0; pre0_tick = 1'b0; pre1_tick = 1'b0;
        end
    endtask

    task automatic accept1();
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    function automatic logic [31:0] mcmd(input logic [1:0] s, input bit rec, input logic [15:0] d);
        return {10'd0, s, 2'b00, 1'b1, rec, d};
    endfunction

    function automatic logic [31:0] scmd(input logic [1:0] s);
        return {10'd0, s, 2'b00, 1'b0, 1'b0, 16'd0};
    endfunction

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        rd(0, 0, r); check("R10 cmd word after reset", r, 32'h0);
        rd(7, 1, r); check("R10 data word after reset", r, 32'h0);
        check("R10 tx_valid after reset", {31'd0, tx_valid}, 32'h0);

        // R1 / R2: vector table on entry 0
        for (int v = 0; v < NV; v++) begin
            logic [31:0] e;
            e = VEC[v];
            wr(0, 0, mcmd(e[31:30], 1'b0, e[15:0]));
            pulse(int'(e[29:28]), int'(e[27:20]));
            rd(0, 0, r);
            check("R1/R2 mark after pulses", {31'd0, r[23]}, {31'd0, e[19]});
            check("R2 tx_valid after pulses", {31'd0, tx_valid}, {31'd0, e[19]});
            wr(0, 0, 32'h0);
        end

        // R6 / R9: reserved and status bits ignored on write
        wr(1, 0, 32'hFFFF_FFFF);
        rd(1, 0, r); check("R6 readback of all-ones write", r, 32'h0033_FFFF);
        check("R9 status bits not writable", {31'd0, tx_valid}, 32'h0);
        wr(1, 0, 32'h0);

        // R4: group layout
        wr(0, 0, scmd(2'd1)); wr(0, 1, 32'hA000_0000);
        wr(2, 0, mcmd(2'd1, 1'b0, 16'd2)); wr(2, 1, 32'hA000_0002);
        wr(3, 0, scmd(2'd1)); wr(3, 1, 32'hA000_0003);
        wr(4, 0, scmd(2'd2)); wr(4, 1, 32'hA000_0004);
        wr(5, 0, mcmd(2'd1, 1'b0, 16'd50)); wr(5, 1, 32'hA000_0005);
        wr(6, 0, scmd(2'd1)); wr(6, 1, 32'hA000_0006);
        pulse(1, 2);
        check("R5 tx_valid after group fire", {31'd0, tx_valid}, 32'h1);
        check("R5 lowest index offered", {29'd0, tx_index}, 32'd2);
        check("R5 offered data", tx_data, 32'hA000_0002);
        rd(3, 0, r); check("R4 matching slave marked", {31'd0, r[23]}, 32'h1);
        rd(4, 0, r); check("R4 mismatched slave idle", {31'd0, r[23]}, 32'h0);
        rd(0, 0, r); check("R4 orphan slave idle", {31'd0, r[23]}, 32'h0);
        rd(6, 0, r); check("R4 other group idle", {31'd0, r[23]}, 32'h0);

        tx_ready = 1'b0; @(negedge clk);
        check("R5 held while not ready", {29'd0, tx_index}, 32'd2);
        accept1();
        check("R5 next index after accept", {29'd0, tx_index}, 32'd3);
        check("R5 next data after accept", tx_data, 32'hA000_0003);
        rd(2, 0, r); check("R7 done set after accept", {31'd0, r[24]}, 32'h1);
        check("R5 accepted mark cleared", {31'd0, r[23]}, 32'h0);
        accept1();
        check("R5 valid drops when drained", {31'd0, tx_valid}, 32'h0);

        // R3: single shot
        pulse(1, 4);
        check("R3 single-shot master stays idle", {31'd0, tx_valid}, 32'h0);

        // R9 / R3 / R8: recyclable rewrite
        wr(2, 0, mcmd(2'd1, 1'b1, 16'd2));
        rd(2, 0, r); check("R9 rewrite clears done", {31'd0, r[24]}, 32'h0);
        pulse(1, 2);
        check("R3 recyclable first fire", {31'd0, tx_valid}, 32'h1);
        accept1(); accept1();
        check("R5 drained after two accepts", {31'd0, tx_valid}, 32'h0);
        pulse(1, 2);
        rd(2, 0, r);
        check("R3 recyclable fires again", {31'd0, r[23]}, 32'h1);
        check("R8 no overrun on clean repeat", {31'd0, r[22]}, 32'h0);
        pulse(1, 2);
        rd(2, 0, r); check("R8 overrun on repeat while marked", {31'd0, r[22]}, 32'h1);
        accept1(); accept1();
        rd(2, 0, r);
        check("R8 overrun sticky after accept", {31'd0, r[22]}, 32'h1);
        check("R7 done sticky", {31'd0, r[24]}, 32'h1);
        wr(2, 1, 32'h1234_5678);
        rd(2, 0, r); check("R9 data write keeps status", r[24:22], 32'h5);
        rd(2, 1, r); check("R9 data word readback", r, 32'h1234_5678);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule